// File: doc/BRIEF.md
# Two-Level Nesting Interrupt Arbiter

This block selects which of eleven interrupt sources an 8-bit CPU core should service next. Each source has an enable bit and a one-bit priority level (low or high). A global enable gates all of them. The block remembers which levels are currently in service, so a high-level source can interrupt a low-level handler. A source never interrupts a handler running at its own level.

When the CPU signals that it can take an interrupt, the block raises a registered request and presents the winner's 16-bit vector address. The CPU answers with an acknowledge strobe, which marks the winner's level as in service. A return strobe releases the most recently entered level.

Three of the sources (power monitor, SPI/I2C and time interval) take their enable and priority bits from a small secondary register on a byte-wide register bus. The other eight take them from input ports.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, irq_req is 0, no level is in service, and reading address 0xA9 returns 0xA0.
- R2: A source is eligible only when its effective enable and glb_en are both 1. A held request from a disabled source produces no irq_req. The same held request is served once the source is enabled.
- R3: Source index equals polling rank, highest first: 0 power monitor, 1 watchdog, 2 external 0, 3 ADC, 4 timer 0, 5 external 1, 6 timer 1, 7 SPI/I2C, 8 serial, 9 timer 2, 10 time interval. Among eligible sources at one level, the lowest index wins.
- R4: When sources of both levels are eligible, a high-level source wins regardless of index.
- R5: The vectors are: 0 → 0x0043, 1 → 0x005B, 2 → 0x0003, 3 → 0x0033, 4 → 0x000B, 5 → 0x0013, 6 → 0x001B, 7 → 0x003B, 8 → 0x0023, 9 → 0x002B, 10 → 0x0053.
- R6: While low is in service, only high-level sources can raise irq_req. Low-level sources are held off.
- R7: While high is in service, no source can raise irq_req.
- R8: A return strobe clears the high in-service bit if it is set, otherwise the low bit.
- R9: irq_req and irq_vec are registered one clock after the inputs. irq_req stays 0 while cpu_ready is 0. An acknowledge while irq_req is 1 marks the winner's level in service and forces irq_req to 0 on the next clock. Arbitration then resumes with the updated state.
- R10: The secondary register is at address 0xA9. Its bits are: bit 6 time-interval priority, bit 5 power-monitor priority, bit 4 SPI/I2C priority, bit 2 time-interval enable, bit 1 power-monitor enable, bit 0 SPI/I2C enable. Bit 7 always reads 1 and bit 3 always reads 0. Other addresses read 0 and ignore writes.
- R11: Source 8 requests when src_req[8] or ser_tx is 1. Source 9 requests when src_req[9] or t2_ext is 1.
- R12: For sources 0, 7 and 10, the src_en and src_hi port bits are ignored. Their enable and priority come from the secondary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 11 | Request lines by polling rank (bit 8 serial receive, bit 9 timer 2 overflow) |
| ser_tx | input | 1 | Serial transmit flag, ORed into source 8 |
| t2_ext | input | 1 | Timer 2 external flag, ORed into source 9 |
| src_en | input | 11 | Per-source enable from the primary enable register |
| src_hi | input | 11 | Per-source priority, 1 = high |
| glb_en | input | 1 | Global interrupt enable |
| cpu_ready | input | 1 | CPU can accept an interrupt |
| irq_ack | input | 1 | CPU accepted the presented interrupt |
| irq_ret | input | 1 | Return from interrupt |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 16 | Vector address of the presented interrupt |
| reg_addr | input | 8 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |

## Verification
The hardest state to reach is two nested levels together with pending requests at both levels. The bench gets there by holding a low source until it is acknowledged. It then raises a second low source and a high source, acknowledges the high one, and adds another high source while both levels are busy. Two return strobes then unwind the nesting one level at a time. After each strobe the bench checks that the correct level reopens: first the waiting high source, and only afterwards the held low source.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter logic [7:0] SEC_ADDR  = 8'hA9,
  parameter int         NSRC      = 11,
  parameter int         VEC_W     = 16,
  localparam int        IDX_W     = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_req,
  input  logic             ser_tx,
  input  logic             t2_ext,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_hi,
  input  logic             glb_en,
  input  logic             cpu_ready,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  input  logic [7:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata
);

  logic [2:0] sec_pri, sec_en;
  logic [1:0] isr;
  logic       irq_lvl;

  wire sec_hit = (reg_addr == SEC_ADDR);
  assign reg_rdata = sec_hit ? {1'b1, sec_pri, 1'b0, sec_en} : 8'h00;

  wire [NSRC-1:0] eff_req = src_req | {1'b0, t2_ext, ser_tx, 8'h00};
  wire [NSRC-1:0] eff_en  = {sec_en[2],  src_en[9:8], sec_en[0],  src_en[6:1], sec_en[1]};
  wire [NSRC-1:0] eff_hi  = {sec_pri[2], src_hi[9:8], sec_pri[0], src_hi[6:1], sec_pri[1]};
  wire [NSRC-1:0] elig    = eff_req & eff_en & {NSRC{glb_en}};

  logic             hi_found, lo_found;
  logic [IDX_W-1:0] hi_idx, lo_idx;

  always_comb begin
    hi_found = 1'b0;
    lo_found = 1'b0;
    hi_idx   = '0;
    lo_idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && eff_hi[i]) begin
        hi_found = 1'b1;
        hi_idx   = IDX_W'(i);
      end
      if (elig[i] && !eff_hi[i]) begin
        lo_found = 1'b1;
        lo_idx   = IDX_W'(i);
      end
    end
  end

  wire              win_hi  = hi_found && !isr[1];
  wire              win_lo  = lo_found && (isr == 2'b00);
  wire              found   = win_hi || win_lo;
  wire [IDX_W-1:0]  win_idx = win_hi ? hi_idx : lo_idx;

  logic [VEC_W-1:0] win_vec;
  always_comb begin
    case (win_idx)
      4'd0:    win_vec = 16'h0043;
      4'd1:    win_vec = 16'h005B;
      4'd2:    win_vec = 16'h0003;
      4'd3:    win_vec = 16'h0033;
      4'd4:    win_vec = 16'h000B;
      4'd5:    win_vec = 16'h0013;
      4'd6:    win_vec = 16'h001B;
      4'd7:    win_vec = 16'h003B;
      4'd8:    win_vec = 16'h0023;
      4'd9:    win_vec = 16'h002B;
      default: win_vec = 16'h0053;
    endcase
  end

  wire take = irq_ack && irq_req;

  logic [1:0] isr_n;
  always_comb begin
    isr_n = isr;
    if (irq_ret) begin
      if (isr[1]) isr_n[1] = 1'b0;
      else        isr_n[0] = 1'b0;
    end
    if (take) isr_n[irq_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_pri <= 3'b010;
      sec_en  <= 3'b000;
      isr     <= 2'b00;
      irq_req <= 1'b0;
      irq_vec <= '0;
      irq_lvl <= 1'b0;
    end else begin
      if (reg_wr && sec_hit) begin
        sec_pri <= reg_wdata[6:4];
        sec_en  <= reg_wdata[2:0];
      end
      isr     <= isr_n;
      irq_req <= cpu_ready && found && !irq_ack;
      irq_vec <= found ? win_vec : '0;
      irq_lvl <= win_hi;
    end
  end

  assert_hi_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    isr[1] |-> !irq_req);

  assert_no_equal_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && isr[0]) |-> irq_lvl);

  assert_ack_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !irq_req);

  assert_ret_hi_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack && isr[1]) |=> (!isr[1] && isr[0] == $past(isr[0])));

  assert_vec_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'b011));

endmodule

// File: tb/irq_nest_ctrl_test.sv
`timescale 1ns/1ps
module irq_nest_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] src_req = '0;
  logic        ser_tx = 1'b0, t2_ext = 1'b0;
  logic [10:0] src_en = '0, src_hi = '0;
  logic        glb_en = 1'b0, cpu_ready = 1'b0, irq_ack = 1'b0, irq_ret = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic [7:0]  reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
  logic        reg_wr = 1'b0;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_nest_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .ser_tx(ser_tx), .t2_ext(t2_ext),
    .src_en(src_en), .src_hi(src_hi), .glb_en(glb_en), .cpu_ready(cpu_ready),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {req, en, hi, expected irq_req, expected vector}
  localparam logic [49:0] TBL [16] = '{
    {11'h000, 11'h7FF, 11'h000, 1'b0, 16'h0000},
    {11'h004, 11'h7FF, 11'h000, 1'b1, 16'h0003},
    {11'h00C, 11'h7FF, 11'h000, 1'b1, 16'h0003},
    {11'h210, 11'h7FF, 11'h000, 1'b1, 16'h000B},
    {11'h018, 11'h7FF, 11'h010, 1'b1, 16'h000B},
    {11'h003, 11'h7FF, 11'h000, 1'b1, 16'h0043},
    {11'h002, 11'h7FD, 11'h000, 1'b0, 16'h0000},
    {11'h100, 11'h7FF, 11'h000, 1'b1, 16'h0023},
    {11'h400, 11'h7FF, 11'h000, 1'b1, 16'h0053},
    {11'h080, 11'h7FF, 11'h000, 1'b1, 16'h003B},
    {11'h040, 11'h7FF, 11'h000, 1'b1, 16'h001B},
    {11'h020, 11'h7FF, 11'h000, 1'b1, 16'h0013},
    {11'h200, 11'h7FF, 11'h000, 1'b1, 16'h002B},
    {11'h002, 11'h7FF, 11'h000, 1'b1, 16'h005B},
    {11'h008, 11'h7FF, 11'h000, 1'b1, 16'h0033},
    {11'h00A, 11'h7FF, 11'h008, 1'b1, 16'h0033}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_irq(input string tag, input logic r, input logic [15:0] v);
    check({tag, " req"}, 32'(irq_req), 32'(r));
    if (r) check({tag, " vec"}, 32'(irq_vec), 32'(v));
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_check(input string tag, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic pulse_ret();
    irq_ret = 1'b1;
    @(negedge clk);
    irq_ret = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_req", 32'(irq_req), 32'd0);
    reg_check("R1 sec reg", 8'hA9, 8'hA0);

    // R10 register layout and masking
    reg_write(8'hA9, 8'hFF);
    reg_check("R10 write ff", 8'hA9, 8'hF7);
    reg_write(8'hA9, 8'h00);
    reg_check("R10 write 00", 8'hA9, 8'h80);
    reg_write(8'hAA, 8'h77);
    reg_check("R10 other addr write ignored", 8'hA9, 8'h80);
    reg_check("R10 other addr reads zero", 8'hAA, 8'h00);

    reg_write(8'hA9, 8'h07);
    glb_en = 1'b1; cpu_ready = 1'b1;

    // table walk: R3 R4 R5 R2
    for (int k = 0; k < 16; k++) begin
      src_req = TBL[k][49:39];
      src_en  = TBL[k][38:28];
      src_hi  = TBL[k][27:17];
      settle();
      expect_irq($sformatf("R3 R4 R5 table %0d", k), TBL[k][16], TBL[k][15:0]);
    end

    // R11 OR-combined sources
    src_en = 11'h7FF; src_hi = '0; src_req = '0;
    ser_tx = 1'b1;
    settle();
    expect_irq("R11 serial tx", 1'b1, 16'h0023);
    ser_tx = 1'b0; t2_ext = 1'b1;
    settle();
    expect_irq("R11 timer2 ext", 1'b1, 16'h002B);
    t2_ext = 1'b0;

    // R12 register-controlled sources ignore port bits
    src_en = 11'h000; src_req = 11'h001;
    settle();
    expect_irq("R12 reg enable wins", 1'b1, 16'h0043);
    reg_write(8'hA9, 8'h00);
    src_en = 11'h7FF; src_req = 11'h401;
    settle();
    expect_irq("R12 reg disable wins", 1'b0, 16'h0000);
    reg_write(8'hA9, 8'h27);
    src_hi = 11'h000; src_req = 11'h00D;
    settle();
    expect_irq("R12 reg priority high", 1'b1, 16'h0043);
    reg_write(8'hA9, 8'h07);
    src_hi = 11'h7FF; src_req = 11'h00C;
    src_hi[3] = 1'b0; src_hi[2] = 1'b0;
    src_req = 11'h081;
    settle();
    expect_irq("R12 port hi ignored", 1'b1, 16'h0043);
    src_hi = '0;

    // R2 global enable gating, held request served later
    glb_en = 1'b0; src_req = 11'h004;
    settle();
    expect_irq("R2 global off", 1'b0, 16'h0000);
    glb_en = 1'b1;
    settle();
    expect_irq("R2 held request served", 1'b1, 16'h0003);

    // R9 cpu_ready gating
    cpu_ready = 1'b0;
    settle();
    expect_irq("R9 not ready", 1'b0, 16'h0000);
    cpu_ready = 1'b1;
    settle();
    expect_irq("R9 ready", 1'b1, 16'h0003);

    // nesting R6 R7 R8 R9
    src_hi = 11'h010;
    pulse_ack();
    check("R9 ack drops request", 32'(irq_req), 32'd0);
    src_req = 11'h024;
    settle();
    expect_irq("R6 low blocked by low", 1'b0, 16'h0000);
    src_req = 11'h034;
    settle();
    expect_irq("R6 high preempts low", 1'b1, 16'h000B);
    pulse_ack();
    check("R9 ack drops high", 32'(irq_req), 32'd0);
    src_hi = 11'h012; src_req = 11'h036;
    settle();
    expect_irq("R7 high in service blocks", 1'b0, 16'h0000);
    pulse_ret();
    settle();
    expect_irq("R8 first return reopens high", 1'b1, 16'h005B);
    src_req = 11'h024;
    settle();
    expect_irq("R8 low still in service", 1'b0, 16'h0000);
    pulse_ret();
    settle();
    expect_irq("R8 second return reopens low", 1'b1, 16'h0003);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule